// File: doc/BRIEF.md
# SMBus Register Slave Interface

This block is a byte-oriented slave for a two-wire SMBus/I2C bus that gives a host access to a bank of eight 8-bit registers. The registers are held outside the block. It reads the clock and data lines after they have been synchronized. It pulls the data line low through a single open-drain enable. It detects START, repeated START and STOP conditions. It decodes the first byte of each transfer against three targets: its own 7-bit device address, a broadcast mass-write address and the alert response address.

The host selects a register with a command byte. Only the low three bits of that byte form the register pointer. A write transfer produces a one-cycle write strobe with pointer and data. Any data byte after the first is acknowledged but has no effect. A read transfer returns the selected register from the register file port. If the host acknowledges a byte, the same register is sent again with no auto-increment. When an alert is pending, an alert response read is acknowledged. The block then signals a request pulse and returns its own address.

Top module: `smb_reg_slave`

## Requirements
- R1: A write of own address with R/W=0, a command byte and one data byte is acknowledged on all three bytes and gives exactly one `wr_en` pulse with `wr_addr` = command[2:0] and `wr_data` = the data byte.
- R2: A second data byte in the same write (Write Word) is acknowledged but gives no further `wr_en` pulse, and no register changes.
- R3: Command bits 7:3 are ignored: command 0x0B writes register 3 and command 0xF3 reads register 3.
- R4: After command, repeated START and own address with R/W=1, the slave acknowledges and shifts out `rd_data` of the pointed register MSB first.
- R5: When the host acknowledges a read byte (Read Word), the slave sends the same register value again.
- R6: Address 0x5F with R/W=0 is acknowledged and its data byte is written like an own-address write; 0x5F with R/W=1 is not acknowledged.
- R7: Address 0x0C with R/W=1 is acknowledged only while `alert_pend` is 1. The slave then gives one single-cycle `ara_req` pulse and sends the byte {dev_addr, 0}. While `alert_pend` is 0, the same address is not acknowledged and no pulse is given.
- R8: Any other address is not acknowledged. After such a byte, the slave neither drives SDA nor writes until the next START.
- R9: A STOP or START in the middle of a byte abandons it without a write. A STOP releases SDA, and the following transfer is decoded from its first bit.
- R10: `sda_oe` changes only while SCL is low.
- R11: Synchronous active-low reset clears `sda_oe`, `wr_en`, `ara_req` and the pointer `rd_addr`.
- R12: `wr_en` is a one-cycle pulse issued while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level (wired-AND of all drivers) |
| dev_addr | input | 7 | Own 7-bit device address |
| alert_pend | input | 1 | An alert is waiting to be answered |
| rd_data | input | 8 | Contents of the register at `rd_addr` |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | output | PTR_W | Current register pointer |
| wr_en | output | 1 | Register write strobe, one cycle |
| wr_addr | output | PTR_W | Register written on `wr_en` |
| wr_data | output | 8 | Byte written on `wr_en` |
| ara_req | output | 1 | Pulse: alert response accepted |

## Verification
The hardest situation to reach is a repeated START that lands in the middle of a data byte, after the address and command have already been acknowledged. The bench's bus master has a task that clocks out only part of a byte and then issues a START. The bench checks that the partial byte is never written and that the next full write lands where it should. The silent period after a non-acknowledged address is reached in a similar way: the master keeps clocking a further byte after the NACK. A behavioural queue of expected writes is compared with `wr_en` on every clock.

// File: rtl/smb_pkg.sv
// Shared types for the SMBus register slave.
// Assumes: 7-bit addressing and 8-bit bytes, fixed by the bus protocol.
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int ADR_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_WEXTRA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } smb_state_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_OWN,
        HIT_MASS,
        HIT_ARA
    } smb_hit_e;
endpackage

// File: rtl/smb_line_mon.sv
// Bus line monitor: finds SCL edges and START/STOP conditions.
// Assumes: scl_i/sda_i are already synchronized to clk; one cycle of history.
module smb_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Keep the previous level of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Edge and condition decode from current and previous levels.
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/smb_addr_match.sv
// Address decoder for the first byte of a transfer.
// Assumes: byte is {addr[6:0], rw}; own address wins over the special ones.
module smb_addr_match
    import smb_pkg::*;
#(
    parameter logic [ADR_W-1:0] MASS_ADDR = 7'h5F,
    parameter logic [ADR_W-1:0] ARA_ADDR  = 7'h0C
) (
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [ADR_W-1:0]  dev_addr,
    input  logic              alert_pend,
    output smb_hit_e          hit
);
    logic [ADR_W-1:0] adr;
    logic             rw;

    // Classify the received address byte.
    always_comb begin
        adr = addr_byte[BYTE_W-1:1];
        rw  = addr_byte[0];
        if (adr == dev_addr)
            hit = HIT_OWN;
        else if (adr == MASS_ADDR && !rw)
            hit = HIT_MASS;
        else if (adr == ARA_ADDR && rw && alert_pend)
            hit = HIT_ARA;
        else
            hit = HIT_NONE;
    end
endmodule

// File: rtl/smb_link_fsm.sv
// Byte-level transfer engine: shifts bytes, drives ACK and read data,
// keeps the register pointer and issues write and alert strobes.
// Assumes: SDA is changed only on a detected SCL fall; START/STOP take
// priority over every state.
module smb_link_fsm
    import smb_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_i,
    input  smb_hit_e          hit,
    input  logic [ADR_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ara_req
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    smb_state_e        state;
    smb_state_e        nxt;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] tx_hold;
    logic              is_ara;
    logic              mack;
    logic [BYTE_W-1:0] tx_first;

    // First byte of a read: own address for an alert answer, else the register.
    assign tx_first = is_ara ? tx_hold : rd_data;
    assign rx_byte  = shreg;

    // Protocol sequencing, one step per detected bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            tx_hold <= '0;
            is_ara  <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            ara_req <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            ara_req <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (start_det) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA, ST_WEXTRA: begin
                        if (scl_rise && bitcnt < LAST_BIT) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_i};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (hit == HIT_NONE) begin
                                        state <= ST_WAIT;
                                    end else begin
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                        is_ara <= (hit == HIT_ARA);
                                        if (hit == HIT_ARA) begin
                                            ara_req <= 1'b1;
                                            tx_hold <= {dev_addr, 1'b0};
                                            nxt     <= ST_TX;
                                        end else if (shreg[0]) begin
                                            nxt <= ST_TX;
                                        end else begin
                                            nxt <= ST_CMD;
                                        end
                                    end
                                end
                                ST_CMD: begin
                                    ptr    <= shreg[PTR_W-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    nxt    <= ST_WDATA;
                                end
                                ST_WDATA: begin
                                    wr_en   <= 1'b1;
                                    wr_data <= shreg;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                    nxt     <= ST_WEXTRA;
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    nxt    <= ST_WEXTRA;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state  <= nxt;
                            bitcnt <= '0;
                            if (nxt == ST_TX) begin
                                tx_hold <= tx_first;
                                shreg   <= tx_first;
                                sda_oe  <= ~tx_first[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise && bitcnt < LAST_BIT) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                                bitcnt <= '0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_i;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg  <= tx_hold;
                                sda_oe <= ~tx_hold[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_reg_slave.sv
// Top of the SMBus register slave: wires the line monitor, the address
// decoder and the transfer engine. Assumes synchronized bus inputs and an
// external register file that returns rd_data for rd_addr combinationally.
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter int               PTR_W     = 3,
    parameter logic [ADR_W-1:0] MASS_ADDR = 7'h5F,
    parameter logic [ADR_W-1:0] ARA_ADDR  = 7'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADR_W-1:0]  dev_addr,
    input  logic              alert_pend,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  rd_addr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ara_req
);
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic [PTR_W-1:0]  ptr;
    smb_hit_e          hit;

    smb_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_addr_match #(
        .MASS_ADDR (MASS_ADDR),
        .ARA_ADDR  (ARA_ADDR)
    ) u_match (
        .addr_byte  (rx_byte),
        .dev_addr   (dev_addr),
        .alert_pend (alert_pend),
        .hit        (hit)
    );

    smb_link_fsm #(
        .PTR_W (PTR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_i     (sda_i),
        .hit       (hit),
        .dev_addr  (dev_addr),
        .rd_data   (rd_data),
        .rx_byte   (rx_byte),
        .sda_oe    (sda_oe),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ara_req   (ara_req)
    );

    assign rd_addr = ptr;
    assign wr_addr = ptr;
endmodule

// File: rtl/smb_reg_slave_chk.sv
// Protocol checker for smb_reg_slave, attached by bind below.
// Assumes the same clock and synchronous active-low reset as the top.
module smb_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_oe,
    input logic wr_en,
    input logic ara_req
);
    // R10: the data driver may only move while the clock is low
    a_r10_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R12: write strobe lasts one cycle
    a_r12_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R12: write strobe only in the low clock phase
    a_r12_wr_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_i);

    // R9: after a STOP the bus is released
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe);

    // R7: alert request is a single pulse
    a_r7_ara_single: assert property (@(posedge clk) disable iff (!rst_n)
        ara_req |=> !ara_req);

    // R11: reset clears the outputs
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !wr_en && !ara_req));
endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .ara_req (ara_req)
);

// File: tb/tb_smb_reg_slave.sv
// Bench: open-drain bus master, behavioural register file and a queue of
// expected writes compared on every clock.
module tb_smb_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam logic [6:0] DEV = 7'h4A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       alert_pend = 1'b0;
    logic       sda_line;
    logic [7:0] rd_data;
    logic       sda_oe;
    logic [2:0] rd_addr;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       ara_req;

    int n_checks = 0;
    int n_fail   = 0;
    int ara_cnt  = 0;
    int stab_bad = 0;
    logic [7:0]  mem [8];
    logic [7:0]  exp_mem [8];
    logic [10:0] exp_q [$];
    logic        prev_scl = 1'b1;
    logic        prev_oe  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    smb_reg_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .dev_addr   (DEV),
        .alert_pend (alert_pend),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ara_req    (ara_req)
    );

    // Register file outside the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 8'hA0 + 8'(i);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Per-clock reference comparison of writes, SDA timing and alert pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R8/R9 unexpected write", {wr_addr, wr_data}, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_data} == e, "R1/R3/R6 write content", {wr_addr, wr_data}, e);
                end
            end
            if (scl_m && prev_scl && sda_oe != prev_oe) stab_bad++;
            if (ara_req) ara_cnt++;
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(4 * HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(HP);
            scl_m = 1'b1; tick(HP);
            scl_m = 1'b0; tick(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP / 2);
        acked = ~sda_line;
        tick(HP - HP / 2);
        scl_m = 1'b0; tick(1);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            scl_m = 1'b1; tick(HP / 2);
            b[i] = sda_line;
            tick(HP - HP / 2);
            scl_m = 1'b0; tick(1);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        scl_m = 1'b0; tick(1);
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d0,
                          input bit word, input logic [7:0] d1, input string req);
        bit ack;
        exp_q.push_back({cmd[2:0], d0});
        exp_mem[cmd[2:0]] = d0;
        bus_start();
        send_byte({a, 1'b0}, ack); chk(ack, {req, " address ack"}, ack, 1);
        send_byte(cmd, ack);       chk(ack, {req, " command ack"}, ack, 1);
        send_byte(d0, ack);        chk(ack, {req, " data ack"}, ack, 1);
        if (word) begin
            send_byte(d1, ack);    chk(ack, "R2 extra byte ack", ack, 1);
        end
        bus_stop();
        chk(exp_q.size() == 0, {req, " write count"}, exp_q.size(), 0);
    endtask

    task automatic rd_txn(input logic [7:0] cmd, input bit word, input logic [7:0] expv,
                          input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, {req, " address ack"}, ack, 1);
        send_byte(cmd, ack);         chk(ack, {req, " command ack"}, ack, 1);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, {req, " read address ack"}, ack, 1);
        recv_byte(word, b);          chk(b == expv, {req, " read data"}, b, expv);
        if (word) begin
            recv_byte(1'b0, b);      chk(b == expv, "R5 repeated byte", b, expv);
        end
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 8; i++) exp_mem[i] = 8'hA0 + 8'(i);
        tick(5);
        // R11: reset state
        chk(sda_oe == 1'b0 && wr_en == 1'b0 && ara_req == 1'b0, "R11 outputs in reset",
            {sda_oe, wr_en, ara_req}, 0);
        rst_n = 1'b1;
        tick(2);
        chk(rd_addr == 3'd0 && sda_oe == 1'b0, "R11 pointer after reset", rd_addr, 0);

        // R1: Write Byte, then R4 read it back
        wr_txn(DEV, 8'h05, 8'h3C, 1'b0, 8'h00, "R1");
        rd_txn(8'h05, 1'b0, 8'h3C, "R4");

        // R2: Write Word keeps only the first byte
        wr_txn(DEV, 8'h02, 8'h11, 1'b1, 8'h22, "R2");
        rd_txn(8'h02, 1'b0, 8'h11, "R2");

        // R3: high command bits ignored
        wr_txn(DEV, 8'h0B, 8'h77, 1'b0, 8'h00, "R3");
        rd_txn(8'hF3, 1'b0, 8'h77, "R3");

        // R5: Read Word repeats the register
        rd_txn(8'h03, 1'b1, 8'h77, "R5");

        // R6: mass write accepted, mass read refused
        wr_txn(7'h5F, 8'h06, 8'h5A, 1'b0, 8'h00, "R6");
        rd_txn(8'h06, 1'b0, 8'h5A, "R6");
        bus_start();
        send_byte({7'h5F, 1'b1}, ack); chk(!ack, "R6 mass read nack", ack, 0);
        bus_stop();

        // R7: alert response only while an alert is pending
        bus_start();
        send_byte({7'h0C, 1'b1}, ack); chk(!ack, "R7 no alert nack", ack, 0);
        bus_stop();
        chk(ara_cnt == 0, "R7 no request without alert", ara_cnt, 0);
        alert_pend = 1'b1;
        bus_start();
        send_byte({7'h0C, 1'b1}, ack); chk(ack, "R7 alert ack", ack, 1);
        recv_byte(1'b0, b);            chk(b == {DEV, 1'b0}, "R7 alert address", b, {DEV, 1'b0});
        bus_stop();
        chk(ara_cnt == 1, "R7 one request", ara_cnt, 1);
        alert_pend = 1'b0;

        // R8: foreign address, slave stays silent
        bus_start();
        send_byte({7'h20, 1'b0}, ack); chk(!ack, "R8 foreign nack", ack, 0);
        send_byte(8'h00, ack);         chk(!ack, "R8 silent after nack", ack, 0);
        send_byte(8'h55, ack);         chk(!ack, "R8 silent on data", ack, 0);
        bus_stop();
        rd_txn(8'h00, 1'b0, exp_mem[0], "R8");

        // R9: STOP mid address byte, then a normal write works
        bus_start();
        send_bits({DEV, 1'b0}, 4);
        bus_stop();
        wr_txn(DEV, 8'h04, 8'hC3, 1'b0, 8'h00, "R9");

        // R9: repeated START mid data byte abandons the byte
        exp_q.push_back({3'd1, 8'h99});
        exp_mem[1] = 8'h99;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R9 address ack", ack, 1);
        send_byte(8'h01, ack);       chk(ack, "R9 command ack", ack, 1);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R9 restart address ack", ack, 1);
        send_byte(8'h01, ack);
        send_byte(8'h99, ack);       chk(ack, "R9 restart data ack", ack, 1);
        bus_stop();
        chk(exp_q.size() == 0, "R9 single write", exp_q.size(), 0);
        rd_txn(8'h01, 1'b0, 8'h99, "R9");
        rd_txn(8'h04, 1'b0, 8'hC3, "R9");

        // R10: no driver change during high clock phase over the run
        chk(stab_bad == 0, "R10 sda held in high phase", stab_bad, 0);
        // R12: all strobes consumed, none left pending
        chk(exp_q.size() == 0, "R12 strobe count", exp_q.size(), 0);
        report();
    end
endmodule